// File: doc/BRIEF.md
# Bus Cycle Wait-State and Ready Controller

This block decides how many extra clock cycles each processor bus cycle receives and drives the active-high ready line that the CPU samples. An external T-state sequencer tells it, with single-cycle pulses, when the end of T1, the middle of T2 and the middle of peripheral state TD2 occur. From those pulses and the extension requests it works out whether a cycle is held, whether a peripheral cycle is in progress, and how many wait states follow. The requests are a continuous-wait line, a peripheral-cycle flag and four binary-weighted wait-count lines, all active low.

A down-counter holds the programmed number of wait states. While continuous wait is sampled low the counter is reloaded from the wait lines. Once the line is high again the counter runs down. This lets the system stretch a cycle for as long as it needs, or cut a long programmed wait short by pulsing continuous wait low with the wait lines released. A hold indication and a wait indication tell the sequencer when to stall and when it may move on to T3.

Each clock of the block is one CPU clock. All requests are sampled on the rising edge, and the outputs come from registered state.

Top module: `wsc_ready_ctrl`

## Requirements
- R1: After synchronous reset, and in the cycle after any clock edge with reset high, rdy is 1 and hold and waiting are 0. A marker arriving afterwards without a preceding end-of-T1 marker has no effect.
- R2: The wait lines wait_n[3:0] are active low, and bit i carries weight 2^i, so the count is the bitwise inverse of the lines. With cwait_n high at the sample point, rdy is low and waiting is high for exactly that many cycles, starting the cycle after the sample. A count of zero adds no wait.
- R3: When cwait_n is low at the end-of-T1 marker, hold goes high and rdy goes low from the next cycle. This lasts for as many cycles as cwait_n is sampled low in a row. The first high sample clears hold on the next cycle.
- R4: When per_n is low at the end-of-T1 marker, the cycle is a peripheral cycle. rdy stays low from the next cycle until the decision, the mid-T2 marker is ignored, and the wait decision is taken at the mid-TD2 marker.
- R5: In a fast cycle (per_n high at end of T1), the wait decision is taken at the mid-T2 marker and the mid-TD2 marker is ignored.
- R6: cwait_n sampled low at the sample point, or during a wait, reloads the counter from the wait lines and keeps rdy low. With c consecutive low samples and count W on the last one, the cycle gets c+W wait states.
- R7: Pulsing cwait_n low for one cycle during a counted wait, with all wait lines high, ends the wait after exactly one more wait cycle.
- R8: If hold and peripheral are requested together at end of T1, hold is served first. The peripheral phase then follows with rdy low, and the wait decision is taken at mid-TD2.
- R9: Sample markers are ignored outside a cycle's sampling window. An end-of-T1 marker during a wait does not disturb the count.
- R10: waiting is high exactly during wait-state cycles, hold exactly during hold cycles, never both together, and rdy is low whenever either is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| t1_end | input | 1 | Sequencer pulse: end of T1 |
| t2_mid | input | 1 | Sequencer pulse: middle of T2 (fast-cycle sample point) |
| td2_mid | input | 1 | Sequencer pulse: middle of TD2 (peripheral sample point) |
| cwait_n | input | 1 | Continuous wait / hold request, active low |
| per_n | input | 1 | Peripheral cycle request, active low |
| wait_n | input | 4 | Binary-weighted wait count, active low |
| rdy | output | 1 | Ready to the CPU, active high |
| hold | output | 1 | Cycle hold in progress |
| waiting | output | 1 | Wait states in progress |

## Verification
Two clashes are provoked on purpose. In the first, cwait_n and per_n are both low at the end-of-T1 marker, so hold and the peripheral request arrive in the same cycle. The bench expects hold for exactly as many cycles as cwait_n stays low, then a peripheral phase with rdy low that ignores mid-T2, then a count decided only at mid-TD2. In the second, a continuous-wait pulse lands in a cycle where the counter is still running down. The reload from the released wait lines must win over the decrement, and the bench judges this by the exact cycle in which rdy rises.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_ARM  = 2'd2,
        ST_WAIT = 2'd3
    } wsc_state_e;

    typedef struct packed {
        logic load;
        logic sub1;
        logic dec;
    } cnt_cmd_t;

    typedef struct packed {
        logic rdy;
        logic hold;
        logic waiting;
    } wsc_out_t;

    function automatic logic pick_sample(input logic per, input logic fast_mark,
                                         input logic per_mark);
        return per ? per_mark : fast_mark;
    endfunction

    function automatic wsc_out_t outs_of(input wsc_state_e st, input logic per);
        wsc_out_t o;
        o.hold    = (st == ST_HOLD);
        o.waiting = (st == ST_WAIT);
        o.rdy     = !(o.hold || o.waiting || ((st == ST_ARM) && per));
        return o;
    endfunction

endpackage

// File: rtl/wsc_wait_decode.sv
module wsc_wait_decode #(
    parameter int LINES = 4
) (
    input  logic [LINES-1:0] wait_n,
    output logic [LINES-1:0] count,
    output logic             nonzero
);
    // each active-low line contributes 2^i when asserted
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign count[i] = ~wait_n[i];
    end

    assign nonzero = |count;
endmodule

// File: rtl/wsc_counter.sv
module wsc_counter
    import wsc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.load) begin
            cnt <= cmd.sub1 ? load_val - CNT_W'(1) : load_val;
        end else if (cmd.dec) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/wsc_seq.sv
module wsc_seq
    import wsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       t1_end,
    input  logic       t2_mid,
    input  logic       td2_mid,
    input  logic       cwait_n,
    input  logic       per_n,
    input  logic       cnt_zero,
    input  logic       count_nz,
    output wsc_state_e state,
    output logic       per_q,
    output cnt_cmd_t   cmd
);
    wsc_state_e nxt;
    logic       per_nxt;
    logic       sample;

    assign sample = pick_sample(per_q, t2_mid, td2_mid);

    always_comb begin
        nxt     = state;
        per_nxt = per_q;
        cmd     = '0;
        unique case (state)
            ST_IDLE: begin
                if (t1_end) begin
                    per_nxt = !per_n;
                    // hold outranks every other request
                    nxt     = cwait_n ? ST_ARM : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (cwait_n) nxt = ST_ARM;
            end
            ST_ARM: begin
                if (sample) begin
                    if (!cwait_n) begin
                        cmd.load = 1'b1;
                        nxt      = ST_WAIT;
                    end else if (count_nz) begin
                        cmd.load = 1'b1;
                        cmd.sub1 = 1'b1;
                        nxt      = ST_WAIT;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_WAIT: begin
                if (!cwait_n) begin
                    cmd.load = 1'b1;
                end else if (cnt_zero) begin
                    nxt = ST_IDLE;
                end else begin
                    cmd.dec = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            per_q <= 1'b0;
        end else begin
            state <= nxt;
            per_q <= per_nxt;
        end
    end
endmodule

// File: rtl/wsc_ready_ctrl.sv
module wsc_ready_ctrl
    import wsc_pkg::*;
#(
    parameter int WAIT_LINES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  t1_end,
    input  logic                  t2_mid,
    input  logic                  td2_mid,
    input  logic                  cwait_n,
    input  logic                  per_n,
    input  logic [WAIT_LINES-1:0] wait_n,
    output logic                  rdy,
    output logic                  hold,
    output logic                  waiting
);
    localparam int CNT_W = WAIT_LINES;

    logic [CNT_W-1:0] count_val;
    logic             count_nz;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;
    wsc_state_e       state;
    logic             per_q;
    cnt_cmd_t         cmd;
    wsc_out_t         outs;

    wsc_wait_decode #(.LINES(WAIT_LINES)) u_dec (
        .wait_n  (wait_n),
        .count   (count_val),
        .nonzero (count_nz)
    );

    wsc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .t1_end   (t1_end),
        .t2_mid   (t2_mid),
        .td2_mid  (td2_mid),
        .cwait_n  (cwait_n),
        .per_n    (per_n),
        .cnt_zero (cnt_zero),
        .count_nz (count_nz),
        .state    (state),
        .per_q    (per_q),
        .cmd      (cmd)
    );

    wsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (count_val),
        .cnt      (cnt_q),
        .zero     (cnt_zero)
    );

    assign outs    = outs_of(state, per_q);
    assign rdy     = outs.rdy;
    assign hold    = outs.hold;
    assign waiting = outs.waiting;
endmodule

// File: rtl/wsc_ready_ctrl_chk.sv
module wsc_ready_ctrl_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cwait_n,
    input logic             rdy,
    input logic             hold,
    input logic             waiting,
    input logic [CNT_W-1:0] cnt
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdy && !hold && !waiting));

    p_hold_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (hold && !cwait_n) |=> hold);

    p_hold_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (hold && cwait_n) |=> (!hold && !waiting));

    p_reload_keeps_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (waiting && !cwait_n) |=> waiting);

    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        (waiting && cwait_n && cnt != '0) |=> (waiting && cnt == $past(cnt) - CNT_W'(1)));

    p_wait_done_r2: assert property (@(posedge clk) disable iff (rst)
        (waiting && cwait_n && cnt == '0) |=> (rdy && !waiting));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hold, waiting}));

    p_rdy_low_r10: assert property (@(posedge clk) disable iff (rst)
        (hold || waiting) |-> !rdy);
endmodule

bind wsc_ready_ctrl wsc_ready_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cwait_n (cwait_n),
    .rdy     (rdy),
    .hold    (hold),
    .waiting (waiting),
    .cnt     (cnt_q)
);

// File: tb/sim_wsc_ready_ctrl.sv
`timescale 1ns/1ps
module sim_wsc_ready_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       t1_end = 1'b0, t2_mid = 1'b0, td2_mid = 1'b0;
    logic       cwait_n = 1'b1, per_n = 1'b1;
    logic [3:0] wait_n = 4'hF;
    logic       rdy, hold, waiting;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        bit    r;
        bit    h;
        bit    w;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    wsc_ready_ctrl u0 (
        .clk(clk), .rst(rst), .t1_end(t1_end), .t2_mid(t2_mid), .td2_mid(td2_mid),
        .cwait_n(cwait_n), .per_n(per_n), .wait_n(wait_n),
        .rdy(rdy), .hold(hold), .waiting(waiting)
    );

    // driver: one call per clock, expectation is for the outputs after the next edge
    task automatic drv(input bit r, input bit a1, input bit a2, input bit a3,
                       input bit cw, input bit pn, input logic [3:0] wn,
                       input bit er, input bit eh, input bit ew, input string tg);
        exp_t e;
        @(negedge clk); #1;
        rst = r; t1_end = a1; t2_mid = a2; td2_mid = a3;
        cwait_n = cw; per_n = pn; wait_n = wn;
        e.r = er; e.h = eh; e.w = ew; e.tag = tg;
        q.push_back(e);
    endtask

    task automatic idle(input bit er, input bit eh, input bit ew, input string tg);
        drv(0, 0, 0, 0, 1, 1, 4'hF, er, eh, ew, tg);
    endtask

    // fast cycle with a counted wait of w cycles
    task automatic fast_cnt(input int w);
        logic [3:0] wv = 4'(w);
        drv(0, 1, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R5");
        if (w > 0) drv(0, 0, 1, 0, 1, 1, ~wv, 0, 0, 1, "R2");
        else       drv(0, 0, 1, 0, 1, 1, ~wv, 1, 0, 0, "R2");
        for (int i = 1; i < w; i++) idle(0, 0, 1, "R2");
        if (w > 0) idle(1, 0, 0, "R2");
    endtask

    // fast cycle: c low samples of continuous wait, count w on them
    task automatic cw_samp(input int c, input int w);
        logic [3:0] wv = 4'(w);
        drv(0, 1, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R5");
        drv(0, 0, 1, 0, 0, 1, ~wv, 0, 0, 1, "R6 R10");
        for (int i = 1; i < c; i++) drv(0, 0, 0, 0, 0, 1, ~wv, 0, 0, 1, "R6");
        for (int i = 0; i < w; i++) idle(0, 0, 1, "R6");
        idle(1, 0, 0, "R6 R7");
    endtask

    // hold for c cycles, optional peripheral request, then count w
    task automatic hold_cyc(input int c, input bit per, input int w);
        logic [3:0] wv = 4'(w);
        drv(0, 1, 0, 0, 0, !per, 4'hF, 0, 1, 0, per ? "R8" : "R3");
        for (int i = 1; i < c; i++) drv(0, 0, 0, 0, 0, 1, 4'hF, 0, 1, 0, "R3 R10");
        drv(0, 0, 0, 0, 1, 1, 4'hF, !per, 0, 0, per ? "R8" : "R3");
        if (per) begin
            drv(0, 0, 1, 0, 1, 1, 4'h0, 0, 0, 0, "R8");
            drv(0, 0, 0, 1, 1, 1, ~wv, w == 0, 0, w > 0, "R8");
        end else begin
            drv(0, 0, 1, 0, 1, 1, ~wv, w == 0, 0, w > 0, "R3");
        end
        for (int i = 1; i < w; i++) idle(0, 0, 1, "R10");
        if (w > 0) idle(1, 0, 0, "R10");
    endtask

    // peripheral cycle with count w decided at mid-TD2
    task automatic per_cyc(input int w);
        logic [3:0] wv = 4'(w);
        drv(0, 1, 0, 0, 1, 0, 4'hF, 0, 0, 0, "R4");
        idle(0, 0, 0, "R4");
        drv(0, 0, 1, 0, 0, 1, 4'h0, 0, 0, 0, "R4");
        idle(0, 0, 0, "R4");
        drv(0, 0, 0, 1, 1, 1, ~wv, w == 0, 0, w > 0, "R4");
        for (int i = 1; i < w; i++) idle(0, 0, 1, "R4");
        if (w > 0) idle(1, 0, 0, "R4");
    endtask

    // monitor: compares outputs shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                compared++;
                if (rdy !== e.r || hold !== e.h || waiting !== e.w) begin
                    mismatched++;
                    $display("FAIL %s: rdy/hold/waiting = %b%b%b, expected %b%b%b at %0t",
                             e.tag, rdy, hold, waiting, e.r, e.h, e.w, $time);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        drv(1, 0, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R1");
        drv(1, 0, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R1");
        idle(1, 0, 0, "R1");
        // R9: markers in idle do nothing
        drv(0, 0, 1, 0, 0, 1, 4'h0, 1, 0, 0, "R9");
        drv(0, 0, 0, 1, 0, 1, 4'h0, 1, 0, 0, "R9");
        // R2: several counts (1 and 4 low = 5)
        fast_cnt(0);
        fast_cnt(1);
        fast_cnt(5);
        fast_cnt(15);
        // R5: mid-TD2 ignored in fast cycle, then idle again
        drv(0, 1, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R5");
        drv(0, 0, 0, 1, 0, 1, 4'h3, 1, 0, 0, "R5");
        drv(0, 0, 1, 0, 1, 1, 4'hF, 1, 0, 0, "R5");
        drv(0, 0, 1, 0, 1, 1, ~4'd4, 1, 0, 0, "R9");
        // R4: peripheral cycles
        per_cyc(0);
        per_cyc(3);
        // R6: continuous wait at the sample point
        cw_samp(1, 0);
        cw_samp(2, 10);
        cw_samp(3, 2);
        // R3, R8: hold alone and hold with peripheral
        hold_cyc(1, 0, 0);
        hold_cyc(4, 0, 2);
        hold_cyc(2, 1, 3);
        // R7: early termination of an 11-cycle wait
        drv(0, 1, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R7");
        drv(0, 0, 1, 0, 1, 1, ~4'd11, 0, 0, 1, "R7");
        idle(0, 0, 1, "R7");
        idle(0, 0, 1, "R7");
        drv(0, 0, 0, 0, 0, 1, 4'hF, 0, 0, 1, "R7");
        idle(1, 0, 0, "R7");
        // R9: end-of-T1 marker during a wait is ignored
        drv(0, 1, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R9");
        drv(0, 0, 1, 0, 1, 1, ~4'd3, 0, 0, 1, "R9");
        drv(0, 1, 0, 0, 1, 1, 4'hF, 0, 0, 1, "R9");
        idle(0, 0, 1, "R9");
        idle(1, 0, 0, "R9");
        // R1: reset in the middle of a wait
        drv(0, 1, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R1");
        drv(0, 0, 1, 0, 1, 1, ~4'd7, 0, 0, 1, "R1");
        drv(1, 0, 0, 0, 1, 1, 4'hF, 1, 0, 0, "R1");
        idle(1, 0, 0, "R1");
        drv(0, 0, 1, 0, 1, 1, ~4'd6, 1, 0, 0, "R1");
        idle(1, 0, 0, "R1");
        @(posedge clk); #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule